// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This unit decides where a sequential 8-bit processor fetches next. Each cycle it takes the current program counter, the length of the instruction in hand, a 16-bit operand, the flag byte, the HL pair, the word at the top of the stack and a branch kind. One clock edge later it presents the registered next program counter and any stack request that goes with it. A push request carries the return address. A pop request tells the stack side that the popped word has been consumed.

Jumps, calls and returns can each be unconditional or conditional. A single eight-entry condition table serves all three kinds, and each entry tests one of four flags for true or false. The unit also handles the eight software restarts, whose vectors are the restart number times eight, and it can load the PC from HL. Interrupt arbitration and the stack storage sit outside the unit.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears `next_pc_o` to 0000h and deasserts `push_req_o` and `pop_req_o` after that edge.
- R2: Every output is registered and reflects the inputs sampled at the previous rising edge. A kind of 0 (sequential), 6 or 7 yields `pc_i + instr_len_i` modulo 2^16 and makes no stack request.
- R3: Condition codes decode as 000 = Z clear, 001 = Z set, 010 = CY clear, 011 = CY set, 100 = P clear, 101 = P set, 110 = S clear and 111 = S set. The flag byte holds S in bit 7, Z in bit 6, P in bit 2 and CY in bit 0. When `is_cond_i` is 0 the branch is always taken.
- R4: For a jump (kind 1), a taken branch yields `operand_i`. A jump that is not taken yields `pc_i + instr_len_i` and makes no stack request.
- R5: For a call (kind 2), a taken branch yields `operand_i` and raises `push_req_o` with `push_data_o = pc_i + instr_len_i`. A call that is not taken behaves as in R4.
- R6: For a return (kind 3), a taken branch yields `stack_word_i` and raises `pop_req_o`. A return that is not taken yields `pc_i + instr_len_i` with no request.
- R7: A restart (kind 4) is never conditional. It yields `rst_num_i * 8`, a vector from 0000h to 0038h, and pushes `pc_i + 1` regardless of `instr_len_i`.
- R8: Kind 5 loads the PC from HL: `next_pc_o = hl_i`, with H as the high byte, and no stack request.
- R9: `push_req_o` and `pop_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 16 | Address of the current instruction |
| instr_len_i | input | 2 | Instruction length in bytes, 1 to 3 |
| operand_i | input | 16 | Jump or call target |
| flags_i | input | 8 | Flag byte (S bit 7, Z bit 6, P bit 2, CY bit 0) |
| hl_i | input | 16 | HL pair, H high |
| stack_word_i | input | 16 | Word at the top of the stack |
| br_kind_i | input | 3 | 0 seq, 1 jump, 2 call, 3 return, 4 restart, 5 load from HL |
| is_cond_i | input | 1 | Apply condition code to jump, call or return |
| cond_i | input | 3 | Condition code |
| rst_num_i | input | 3 | Restart number |
| next_pc_o | output | 16 | Registered next program counter |
| push_req_o | output | 1 | Push the return address |
| push_data_o | output | 16 | Return address to push |
| pop_req_o | output | 1 | Top-of-stack word consumed |

## Verification
The assertions assume that `instr_len_i` always lies between 1 and 3. They also assume that `stack_word_i` is valid whenever a return is presented. The random stimulus draws lengths only from 1 to 3 and draws every kind code, including the unused codes 6 and 7. Flags and condition codes are drawn uniformly, so each condition table entry is exercised both taken and not taken. Directed cases cover each restart vector, the wrap of the PC at FFFFh, and each condition code against a set and a clear flag.

// File: rtl/npc_pkg.sv
// Shared definitions for the next-PC unit: widths, branch kinds and flag
// bit positions inside the flag byte. Assumes an 8-bit flag byte.
package npc_pkg;
    localparam int ADDR_W   = 16;
    localparam int FLAG_W   = 8;
    localparam int COND_W   = 3;
    localparam int KIND_W   = 3;
    localparam int LEN_W    = 2;
    localparam int VEC_SHIFT = 3;

    localparam int FLAG_S  = 7;
    localparam int FLAG_Z  = 6;
    localparam int FLAG_P  = 2;
    localparam int FLAG_CY = 0;

    typedef enum logic [KIND_W-1:0] {
        BK_SEQ  = 3'd0,
        BK_JUMP = 3'd1,
        BK_CALL = 3'd2,
        BK_RET  = 3'd3,
        BK_RST  = 3'd4,
        BK_HL   = 3'd5
    } br_kind_e;
endpackage

// File: rtl/npc_cond_eval.sv
// Evaluates one of eight branch conditions against the flag byte.
// Code bits [2:1] pick the flag (Z, CY, P, S); bit 0 is the value it must have.
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int N_COND = 1 << COND_W
) (
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              met_o
);
    logic [N_COND-1:0] table_q;

    // One table entry per code: flag under test equals the wanted polarity.
    for (genvar i = 0; i < N_COND; i++) begin : g_entry
        localparam logic [COND_W-1:0] CODE = COND_W'(i);
        localparam int BITPOS = (CODE[2:1] == 2'd0) ? FLAG_Z  :
                                (CODE[2:1] == 2'd1) ? FLAG_CY :
                                (CODE[2:1] == 2'd2) ? FLAG_P  : FLAG_S;
        assign table_q[i] = (flags_i[BITPOS] == CODE[0]);
    end

    // Select the entry named by the condition code.
    assign met_o = table_q[cond_i];
endmodule

// File: rtl/npc_target_sel.sv
// Combinational choice of next PC and stack requests for one instruction.
// Assumes instr_len_i is 1..3 and that stack_word_i is valid on returns.
module npc_target_sel
    import npc_pkg::*;
(
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [LEN_W-1:0]  instr_len_i,
    input  logic [ADDR_W-1:0] operand_i,
    input  logic [ADDR_W-1:0] hl_i,
    input  logic [ADDR_W-1:0] stack_word_i,
    input  logic [KIND_W-1:0] br_kind_i,
    input  logic              taken_i,
    input  logic [COND_W-1:0] rst_num_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              push_o,
    output logic [ADDR_W-1:0] push_data_o,
    output logic              pop_o
);
    localparam int VEC_PAD = ADDR_W - COND_W - VEC_SHIFT;

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] rst_vec;

    assign seq_pc  = pc_i + ADDR_W'(instr_len_i);
    assign rst_vec = {{VEC_PAD{1'b0}}, rst_num_i, {VEC_SHIFT{1'b0}}};

    // Pick the destination and stack action for the branch kind.
    always_comb begin
        next_pc_o   = seq_pc;
        push_o      = 1'b0;
        push_data_o = seq_pc;
        pop_o       = 1'b0;
        case (br_kind_i)
            BK_JUMP: if (taken_i) next_pc_o = operand_i;
            BK_CALL: if (taken_i) begin
                next_pc_o = operand_i;
                push_o    = 1'b1;
            end
            BK_RET: if (taken_i) begin
                next_pc_o = stack_word_i;
                pop_o     = 1'b1;
            end
            BK_RST: begin
                next_pc_o   = rst_vec;
                push_o      = 1'b1;
                push_data_o = pc_i + ADDR_W'(1);
            end
            BK_HL:   next_pc_o = hl_i;
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
// Next-PC unit top: evaluates the branch condition, selects the target and
// registers the result. Synchronous active-low reset clears the outputs.
module npc_unit
    import npc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       pc_i,
    input  logic [1:0]        instr_len_i,
    input  logic [15:0]       operand_i,
    input  logic [7:0]        flags_i,
    input  logic [15:0]       hl_i,
    input  logic [15:0]       stack_word_i,
    input  logic [2:0]        br_kind_i,
    input  logic              is_cond_i,
    input  logic [2:0]        cond_i,
    input  logic [2:0]        rst_num_i,
    output logic [15:0]       next_pc_o,
    output logic              push_req_o,
    output logic [15:0]       push_data_o,
    output logic              pop_req_o
);
    logic              cond_met;
    logic              taken;
    logic [ADDR_W-1:0] nxt_pc;
    logic              nxt_push;
    logic [ADDR_W-1:0] nxt_data;
    logic              nxt_pop;

    npc_cond_eval u_cond (
        .flags_i (flags_i),
        .cond_i  (cond_i),
        .met_o   (cond_met)
    );

    assign taken = !is_cond_i || cond_met;

    npc_target_sel u_sel (
        .pc_i         (pc_i),
        .instr_len_i  (instr_len_i),
        .operand_i    (operand_i),
        .hl_i         (hl_i),
        .stack_word_i (stack_word_i),
        .br_kind_i    (br_kind_i),
        .taken_i      (taken),
        .rst_num_i    (rst_num_i),
        .next_pc_o    (nxt_pc),
        .push_o       (nxt_push),
        .push_data_o  (nxt_data),
        .pop_o        (nxt_pop)
    );

    // Register the decision; reset parks the PC at zero with no requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o   <= '0;
            push_req_o  <= 1'b0;
            push_data_o <= '0;
            pop_req_o   <= 1'b0;
        end else begin
            next_pc_o   <= nxt_pc;
            push_req_o  <= nxt_push;
            push_data_o <= nxt_data;
            pop_req_o   <= nxt_pop;
        end
    end
endmodule

// File: rtl/npc_unit_chk.sv
// Checker for npc_unit: temporal properties over its ports, bound below.
// Assumes instr_len_i stays within 1..3.
module npc_unit_chk
    import npc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] pc_i,
    input logic [1:0]  instr_len_i,
    input logic [2:0]  br_kind_i,
    input logic [2:0]  rst_num_i,
    input logic [15:0] next_pc_o,
    input logic        push_req_o,
    input logic [15:0] push_data_o,
    input logic        pop_req_o
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!push_req_o && !pop_req_o && next_pc_o == 16'h0000));

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind_i == BK_SEQ) |=> (!push_req_o && !pop_req_o &&
            next_pc_o == $past(pc_i) + 16'($past(instr_len_i))));

    assert_call_retaddr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind_i == BK_CALL) |=> (!push_req_o ||
            push_data_o == $past(pc_i) + 16'($past(instr_len_i))));

    assert_pop_from_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind_i != BK_RET) |=> !pop_req_o);

    assert_restart_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind_i == BK_RST) |=> (push_req_o &&
            next_pc_o == {10'd0, $past(rst_num_i), 3'd0} &&
            push_data_o == $past(pc_i) + 16'd1));

    assert_hl_nostack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind_i == BK_HL) |=> (!push_req_o && !pop_req_o));

    assert_push_pop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req_o && pop_req_o));
endmodule

bind npc_unit npc_unit_chk u_chk (.*);

// File: tb/npc_unit_bench.sv
// Bench for npc_unit: seeded random mix plus directed corners, compared
// against a reference model written from the requirements.
module npc_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_i = '0, operand_i = '0, hl_i = '0, stack_word_i = '0;
    logic [1:0]  instr_len_i = 2'd1;
    logic [7:0]  flags_i = '0;
    logic [2:0]  br_kind_i = '0, cond_i = '0, rst_num_i = '0;
    logic        is_cond_i = 1'b0;
    logic [15:0] next_pc_o, push_data_o;
    logic        push_req_o, pop_req_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit u_npc_unit (.*);

    // Condition table model (R3).
    function automatic bit cond_ok(input logic [7:0] f, input logic [2:0] c);
        case (c)
            3'd0: return f[6] == 1'b0;
            3'd1: return f[6] == 1'b1;
            3'd2: return f[0] == 1'b0;
            3'd3: return f[0] == 1'b1;
            3'd4: return f[2] == 1'b0;
            3'd5: return f[2] == 1'b1;
            3'd6: return f[7] == 1'b0;
            default: return f[7] == 1'b1;
        endcase
    endfunction

    // Expected {next_pc, push, push_data, pop}.
    function automatic logic [33:0] model();
        logic [15:0] seq = pc_i + {14'd0, instr_len_i};
        bit tk = !is_cond_i || cond_ok(flags_i, cond_i);
        case (br_kind_i)
            3'd1: return tk ? {operand_i, 1'b0, seq, 1'b0} : {seq, 1'b0, seq, 1'b0};
            3'd2: return tk ? {operand_i, 1'b1, seq, 1'b0} : {seq, 1'b0, seq, 1'b0};
            3'd3: return tk ? {stack_word_i, 1'b0, seq, 1'b1} : {seq, 1'b0, seq, 1'b0};
            3'd4: return {16'(rst_num_i) * 16'd8, 1'b1, pc_i + 16'd1, 1'b0};
            3'd5: return {hl_i, 1'b0, seq, 1'b0};
            default: return {seq, 1'b0, seq, 1'b0};
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R2";
        endcase
    endfunction

    // Apply current inputs for one edge and compare after it.
    task automatic step(input string tag);
        logic [33:0] exp = model();
        @(posedge clk);
        #1;
        n_run++;
        if (next_pc_o !== exp[33:18] || push_req_o !== exp[17] || pop_req_o !== exp[0] ||
            (exp[17] && push_data_o !== exp[16:1]) || (push_req_o && pop_req_o)) begin
            n_fail++;
            $display("FAIL %s: got pc=%h push=%b data=%h pop=%b expected pc=%h push=%b data=%h pop=%b",
                     tag, next_pc_o, push_req_o, push_data_o, pop_req_o,
                     exp[33:18], exp[17], exp[16:1], exp[0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state.
        pc_i = 16'h1234; br_kind_i = 3'd4; rst_num_i = 3'd5;
        repeat (2) @(posedge clk);
        #1;
        n_run++;
        if (next_pc_o !== 16'h0 || push_req_o !== 1'b0 || pop_req_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got pc=%h push=%b pop=%b expected 0000 0 0",
                     next_pc_o, push_req_o, pop_req_o);
        end
        rst_n = 1'b1;

        // R2: wrap at FFFFh.
        br_kind_i = 3'd0; pc_i = 16'hFFFE; instr_len_i = 2'd3; step("R2");
        br_kind_i = 3'd7; step("R2");

        // R3: each code against clear and set flag byte, via conditional jump.
        br_kind_i = 3'd1; is_cond_i = 1'b1; operand_i = 16'hBEEF; pc_i = 16'h0100; instr_len_i = 2'd3;
        for (int c = 0; c < 8; c++) begin
            cond_i = 3'(c);
            flags_i = 8'h00; step("R3");
            flags_i = 8'hC5; step("R3");
        end

        // R7: every restart vector, length ignored.
        is_cond_i = 1'b1; flags_i = 8'h00; cond_i = 3'd1; br_kind_i = 3'd4; instr_len_i = 2'd3;
        for (int n = 0; n < 8; n++) begin
            rst_num_i = 3'(n); pc_i = 16'h2000 + 16'(n); step("R7");
        end

        // R8: PC from HL.
        br_kind_i = 3'd5; hl_i = 16'h2500; step("R8");

        // R5 and R6: unconditional call and return.
        is_cond_i = 1'b0; br_kind_i = 3'd2; pc_i = 16'hFFFF; step("R5");
        br_kind_i = 3'd3; stack_word_i = 16'h4321; step("R6");

        // Random mix (R2 to R9).
        for (int i = 0; i < 3000; i++) begin
            pc_i = 16'($urandom); operand_i = 16'($urandom); hl_i = 16'($urandom);
            stack_word_i = 16'($urandom); flags_i = 8'($urandom);
            instr_len_i = 2'(1 + $urandom % 3); br_kind_i = 3'($urandom);
            is_cond_i = 1'($urandom); cond_i = 3'($urandom); rst_num_i = 3'($urandom);
            step(tag_of(br_kind_i));
        end
        finish_run();
    end
endmodule